// File: doc/BRIEF.md
# Voltage Reference Ramp Generator

This block produces the 8-bit code that selects a tap on a resistor-ladder reference for a core-voltage regulator. Code 00h stands for 0 V. Code 01h stands for 0.5 V, and each higher code adds 10 mV. The commanded target is a VID code plus a signed offset, limited to a programmable ceiling. The block does not jump to the target. It moves the output one code at a time, so the reference forms a staircase. The pace is set by a fast or a slow rate, counted in ticks of an external time base.

A command strobe loads a new target while the output is at rest or mid-ramp. The ramp turns around from the code the output holds at that moment. A separate boot strobe loads the start-up target and always uses the slow rate. A busy flag is high while the output differs from the target. A one-cycle done pulse, meant to drive the host alert line, marks each arrival at the target.

Top module: `vid_ramp_gen`

## Requirements
- R1: While rst_n is low at a clock edge, ref_code becomes 00h and target becomes 00h, so busy and done are both low after the edge.
- R2: For a nonzero VID, the target is vid_code plus vid_offset, with vid_offset read as an 8-bit two's-complement value. A sum of zero or below becomes 01h, the lowest nonzero code (0.5 V).
- R3: A vid_code of 00h gives a target of 00h (0 V), whatever the offset. A ramp toward it passes through 01h and then steps to 00h.
- R4: The target never exceeds vout_max. A larger sum, or a larger boot code, is replaced by vout_max.
- R5: ref_code changes by exactly one code per clock at most. It moves only toward the target, and only on an edge where tick is high.
- R6: The rate is chosen at each command load. When slew_fast is 1, ref_code steps once per FAST_TICKS ticks (default 1). Otherwise it steps once per SLOW_TICKS ticks (default 4).
- R7: boot_load loads boot_code, limited as in R4, as the target and always uses the slow rate. If boot_load and load are high together, boot_load wins.
- R8: A load during a ramp leaves ref_code unchanged on that edge and restarts the tick count. Stepping then continues toward the new target from the current code.
- R9: busy is high exactly when ref_code differs from the target. done is high for one cycle after the edge on which ref_code reaches the target, or after a load whose target equals the current code.
- R10: When a load and a tick arrive on the same edge, the load wins and ref_code does not step on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle time-base pulse (e.g. 1 µs) |
| load | input | 1 | Load the commanded target from vid_code and vid_offset |
| boot_load | input | 1 | Load the boot target at the slow rate |
| slew_fast | input | 1 | Rate for load: 1 fast, 0 slow |
| vid_code | input | 8 | Commanded VID code |
| vid_offset | input | 8 | Signed offset in code steps |
| boot_code | input | 8 | Start-up VID code |
| vout_max | input | 8 | Highest allowed target code |
| ref_code | output | 8 | Current ladder select code |
| busy | output | 1 | Output has not reached target |
| done | output | 1 | One-cycle arrival pulse |

## Verification
The checker assumes that vout_max is held steady and is changed only while the block is idle with a target below the new value. Its ceiling property is not valid if the limit drops under a settled code. It also assumes that tick, load and boot_load are single-cycle pulses sampled on the clock. The stimulus sets vout_max only between scenarios, after the previous ramp has settled. The reference model recomputes the saturated target from the requirement arithmetic and tracks the tick count itself, so every cycle is compared, including cycles where a load coincides with a tick.

// File: rtl/vid_ramp_pkg.sv
// Package: shared widths and types for the reference ramp generator.
// Assumes 8-bit VID codes, where 00h is 0 V and 01h upward is 0.5 V + n*10 mV.
package vid_ramp_pkg;
    localparam int CODE_W = 8;
    typedef logic [CODE_W-1:0] vid_code_t;
    typedef enum logic {RATE_FAST = 1'b0, RATE_SLOW = 1'b1} rate_e;
endpackage

// File: rtl/vid_target_calc.sv
// Module: vid_target_calc
// Forms the target code from a base code plus a signed offset, saturated into
// [01h, limit]. A base of 00h means 0 V and always yields 00h.
// Assumes limit is a legal code. Purely combinational.
module vid_target_calc
    import vid_ramp_pkg::*;
(
    input  vid_code_t base,
    input  vid_code_t offset,
    input  vid_code_t limit,
    output vid_code_t target
);
    localparam int SUM_W = CODE_W + 2;

    logic signed [SUM_W-1:0] sum;
    logic [CODE_W-1:0]       low_clamped;

    // Signed sum of the base and the sign-extended offset.
    always_comb begin
        sum = $signed({2'b00, base}) + $signed({{2{offset[CODE_W-1]}}, offset});
    end

    // Clamp first to the lowest nonzero code, then to the ceiling.
    always_comb begin
        if (sum < $signed(SUM_W'(1)))
            low_clamped = CODE_W'(1);
        else if (sum > $signed(SUM_W'({CODE_W{1'b1}})))
            low_clamped = {CODE_W{1'b1}};
        else
            low_clamped = sum[CODE_W-1:0];

        if (base == '0)
            target = '0;
        else if (low_clamped > limit)
            target = limit;
        else
            target = low_clamped;
    end
endmodule

// File: rtl/ramp_pacer.sv
// Module: ramp_pacer
// Counts ticks and issues one step request every FAST_TICKS or SLOW_TICKS ticks
// while a ramp is active. A restart clears the count and suppresses the step.
// Assumes both tick limits are at least 1.
module ramp_pacer
    import vid_ramp_pkg::*;
#(
    parameter int FAST_TICKS = 1,
    parameter int SLOW_TICKS = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  restart,
    input  logic  tick,
    input  logic  active,
    input  rate_e rate,
    output logic  step
);
    localparam int MAX_TICKS = (FAST_TICKS > SLOW_TICKS) ? FAST_TICKS : SLOW_TICKS;
    localparam int CNT_W     = (MAX_TICKS > 1) ? $clog2(MAX_TICKS) : 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;
    logic             wrap;

    // Pick the terminal count for the latched rate.
    generate
        if (FAST_TICKS == SLOW_TICKS) begin : g_single_rate
            always_comb last = CNT_W'(FAST_TICKS - 1);
        end else begin : g_two_rates
            always_comb last = (rate == RATE_SLOW) ? CNT_W'(SLOW_TICKS - 1)
                                                   : CNT_W'(FAST_TICKS - 1);
        end
    endgenerate

    // Decide whether this tick completes a step interval.
    always_comb begin
        wrap = (cnt_q >= last);
        step = tick && active && !restart && wrap;
    end

    // Tick counter: cleared on reset and restart, advanced on active ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            cnt_q <= '0;
        else if (tick && active)
            cnt_q <= wrap ? '0 : cnt_q + CNT_W'(1);
    end
endmodule

// File: rtl/ramp_stepper.sv
// Module: ramp_stepper
// Holds the output code and moves it by one code toward the target on each
// step request. Raises a one-cycle done pulse on arrival, or on a reload whose
// target equals the current code. Assumes step is low during a reload.
module ramp_stepper
    import vid_ramp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      reload,
    input  vid_code_t reload_tgt,
    input  vid_code_t tgt,
    input  logic      step,
    output vid_code_t code,
    output logic      done
);
    vid_code_t code_q;
    vid_code_t code_nxt;
    logic      done_q;

    // Neighbouring code in the direction of the target.
    always_comb begin
        code_nxt = (code_q < tgt) ? code_q + CODE_W'(1) : code_q - CODE_W'(1);
    end

    // Output code register: a single code move per granted step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            code_q <= '0;
        else if (step && !reload)
            code_q <= code_nxt;
    end

    // Arrival pulse: set on reaching the target, otherwise cleared next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done_q <= 1'b0;
        else if (reload)
            done_q <= (reload_tgt == code_q);
        else
            done_q <= step && (code_nxt == tgt);
    end

    assign code = code_q;
    assign done = done_q;
endmodule

// File: rtl/vid_ramp_gen.sv
// Module: vid_ramp_gen (top)
// Reference ramp generator. It latches a target from a command or boot load,
// then stairsteps ref_code toward it at the latched rate.
// Assumes tick, load and boot_load are one-cycle pulses and vout_max is quasi-static.
module vid_ramp_gen
    import vid_ramp_pkg::*;
#(
    parameter int FAST_TICKS = 1,
    parameter int SLOW_TICKS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       load,
    input  logic       boot_load,
    input  logic       slew_fast,
    input  logic [7:0] vid_code,
    input  logic [7:0] vid_offset,
    input  logic [7:0] boot_code,
    input  logic [7:0] vout_max,
    output logic [7:0] ref_code,
    output logic       busy,
    output logic       done
);
    vid_code_t cmd_tgt;
    vid_code_t boot_tgt;
    vid_code_t new_tgt;
    vid_code_t tgt_q;
    rate_e     rate_q;
    logic      reload;
    logic      step;
    vid_code_t code;

    vid_target_calc u_cmd_calc (
        .base   (vid_code),
        .offset (vid_offset),
        .limit  (vout_max),
        .target (cmd_tgt)
    );

    vid_target_calc u_boot_calc (
        .base   (boot_code),
        .offset (8'h00),
        .limit  (vout_max),
        .target (boot_tgt)
    );

    // Select the target being loaded this cycle; boot has priority.
    always_comb begin
        reload  = load || boot_load;
        new_tgt = boot_load ? boot_tgt : cmd_tgt;
    end

    // Target and rate registers, written only by a load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q  <= '0;
            rate_q <= RATE_SLOW;
        end else if (boot_load) begin
            tgt_q  <= boot_tgt;
            rate_q <= RATE_SLOW;
        end else if (load) begin
            tgt_q  <= cmd_tgt;
            rate_q <= slew_fast ? RATE_FAST : RATE_SLOW;
        end
    end

    ramp_pacer #(
        .FAST_TICKS (FAST_TICKS),
        .SLOW_TICKS (SLOW_TICKS)
    ) u_pacer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (reload),
        .tick    (tick),
        .active  (busy),
        .rate    (rate_q),
        .step    (step)
    );

    ramp_stepper u_stepper (
        .clk        (clk),
        .rst_n      (rst_n),
        .reload     (reload),
        .reload_tgt (new_tgt),
        .tgt        (tgt_q),
        .step       (step),
        .code       (code),
        .done       (done)
    );

    // Busy whenever the staircase has not reached the latched target.
    always_comb begin
        busy     = (code != tgt_q);
        ref_code = code;
    end
endmodule

// File: rtl/vid_ramp_gen_chk.sv
// Module: vid_ramp_gen_chk
// Port-level properties of the ramp generator, bound to every instance.
// Assumes vout_max does not drop below a settled code.
module vid_ramp_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       load,
    input logic       boot_load,
    input logic [7:0] vout_max,
    input logic [7:0] ref_code,
    input logic       busy,
    input logic       done
);
    // R1: reset clears the code and the done pulse.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (ref_code == 8'h00 && !done && !busy));

    // R5: at most one code of movement per clock.
    assert_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ref_code == $past(ref_code) ||
                  ref_code == $past(ref_code) + 8'd1 ||
                  ref_code == $past(ref_code) - 8'd1));

    // R5: no movement without a tick.
    assert_tick_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(ref_code));

    // R10: a load edge never moves the code.
    assert_load_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (load || boot_load) |=> $stable(ref_code));

    // R9: done only at rest.
    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9: done lasts one cycle unless a reload re-arms it.
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load && !boot_load) |=> !done);

    // R4: a settled code respects the ceiling.
    assert_ceiling_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ref_code <= vout_max);
endmodule

bind vid_ramp_gen vid_ramp_gen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .load      (load),
    .boot_load (boot_load),
    .vout_max  (vout_max),
    .ref_code  (ref_code),
    .busy      (busy),
    .done      (done)
);

// File: tb/test_vid_ramp_gen.sv
// Bench: drives loads and a tick every other cycle, keeps a behavioural model
// of the staircase in integers, and compares the outputs on every clock.
module test_vid_ramp_gen;
    localparam int FAST_N = 1;
    localparam int SLOW_N = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       load = 1'b0;
    logic       boot_load = 1'b0;
    logic       slew_fast = 1'b0;
    logic [7:0] vid_code = 8'h00;
    logic [7:0] vid_offset = 8'h00;
    logic [7:0] boot_code = 8'h00;
    logic [7:0] vout_max = 8'hFF;
    logic [7:0] ref_code;
    logic       busy;
    logic       done;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    bit tick_en = 1'b0;
    bit finished = 1'b0;
    string cur_req = "R1";

    // Model state.
    int m_code = 0, m_tgt = 0, m_cnt = 0, m_done = 0;
    bit m_slow = 1'b1;

    always #2 clk = ~clk;

    vid_ramp_gen #(.FAST_TICKS(FAST_N), .SLOW_TICKS(SLOW_N)) i_vid_ramp_gen (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(load), .boot_load(boot_load),
        .slew_fast(slew_fast), .vid_code(vid_code), .vid_offset(vid_offset),
        .boot_code(boot_code), .vout_max(vout_max), .ref_code(ref_code),
        .busy(busy), .done(done)
    );

    function automatic int calc_tgt(int base, int off, int vmax);
        int s;
        if (base == 0) return 0;
        s = base + ((off > 127) ? off - 256 : off);
        if (s < 1) s = 1;
        if (s > vmax) s = vmax;
        return s;
    endfunction

    // Behavioural model update on each rising edge.
    always @(posedge clk) begin
        int t;
        if (!rst_n) begin
            m_code = 0; m_tgt = 0; m_cnt = 0; m_done = 0; m_slow = 1'b1;
        end else if (boot_load || load) begin
            t = boot_load ? calc_tgt(boot_code, 0, vout_max)
                          : calc_tgt(vid_code, vid_offset, vout_max);
            m_tgt = t; m_cnt = 0;
            m_slow = boot_load ? 1'b1 : !slew_fast;
            m_done = (t == m_code);
        end else begin
            m_done = 0;
            if (tick && m_code != m_tgt) begin
                if (m_cnt >= (m_slow ? SLOW_N : FAST_N) - 1) begin
                    m_cnt = 0;
                    m_code += (m_code < m_tgt) ? 1 : -1;
                    if (m_code == m_tgt) m_done = 1;
                end else begin
                    m_cnt++;
                end
            end
        end
    end

    task automatic check(string req, int got, int exp, string what);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    // One cycle: compare at the falling edge, then drive the next inputs.
    task automatic cycle(bit do_load, bit do_boot, bit force_tick);
        @(negedge clk);
        check(cur_req, ref_code, m_code, "ref_code");
        check(cur_req, busy, (m_code != m_tgt), "busy");
        check(cur_req, done, m_done, "done");
        load      = do_load;
        boot_load = do_boot;
        tick      = force_tick || (tick_en && (cyc % 2 == 0));
        cyc++;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) cycle(1'b0, 1'b0, 1'b0);
    endtask

    task automatic cmd(int v, int off, bit fast);
        vid_code = 8'(v); vid_offset = 8'(off); slew_fast = fast;
        cycle(1'b1, 1'b0, 1'b0);
    endtask

    initial begin
        run(3);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        check("R1", ref_code, 0, "reset code");
        check("R1", busy, 0, "reset busy");
        tick_en = 1'b1;

        // R7: boot ramp at the slow rate.
        cur_req = "R7";
        boot_code = 8'h20; slew_fast = 1'b1;
        cycle(1'b0, 1'b1, 1'b0);
        run(64);
        check("R7", (ref_code <= 8'h09) ? 1 : 0, 1, "slow boot progress");
        run(240);
        check("R7", ref_code, 8'h20, "boot arrival");

        // R6/R2: fast rise.
        cur_req = "R6";
        cmd(8'h40, 0, 1'b1);
        run(80);
        check("R6", ref_code, 8'h40, "fast arrival");

        // R2: negative offset, slow fall.
        cur_req = "R2";
        cmd(8'h30, 8'hFC, 1'b0);
        run(200);
        check("R2", ref_code, 8'h2C, "offset target");

        // R4: ceiling clamp.
        cur_req = "R4";
        vout_max = 8'h35;
        cmd(8'h33, 10, 1'b1);
        run(40);
        check("R4", ref_code, 8'h35, "clamped target");

        // R3: VID 00h goes to 0 V whatever the offset.
        cur_req = "R3";
        cmd(8'h00, 10, 1'b1);
        run(130);
        check("R3", ref_code, 8'h00, "zero target");

        // R2: low clamp to 01h.
        cur_req = "R2";
        vout_max = 8'hFF;
        cmd(8'h03, 8'hF6, 1'b1);
        run(20);
        check("R2", ref_code, 8'h01, "low clamp");

        // R8: redirect mid-ramp.
        cur_req = "R8";
        cmd(8'h30, 0, 1'b1);
        run(20);
        check("R8", (ref_code > 8'h01 && ref_code < 8'h30) ? 1 : 0, 1, "mid ramp");
        cmd(8'h08, 0, 1'b1);
        run(120);
        check("R8", ref_code, 8'h08, "redirected arrival");

        // R9: reload of the same target pulses done at once.
        cur_req = "R9";
        cmd(8'h08, 0, 1'b1);
        @(negedge clk);
        check("R9", done, 1, "done on equal reload");
        check("R9", busy, 0, "idle on equal reload");
        cycle(1'b0, 1'b0, 1'b0);

        // R10: load and tick together do not step.
        cur_req = "R10";
        vid_code = 8'h0A; vid_offset = 0; slew_fast = 1'b1;
        cycle(1'b1, 1'b0, 1'b1);
        @(negedge clk);
        check("R10", ref_code, 8'h08, "no step on load edge");
        run(20);
        check("R10", ref_code, 8'h0A, "later arrival");

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule